// File: doc/BRIEF.md
# Bus-Matching Port Width Adapter

This block sits between an 80-bit-wide word store and two narrower external buses. On the write side it gathers narrow input words into one 80-bit long-word. It hands that long-word to the store through a valid/ready pair. On the read side it accepts one 80-bit long-word from the store and releases it as a series of narrow words, one per enabled read.

Each side has its own width of 80, 40, 20 or 10 bits. A two-bit size code picks the width. The read side can also hand out segments in high-first or low-first order. The block samples the two size codes and the order selection while the master reset is asserted, and keeps them fixed after that. A narrow word always travels on the low bits of its bus.

Top module: `bm_port_adapter`

## Requirements
- R1: Size code 00 selects 80 bits, 01 selects 40, 10 selects 20 and 11 selects 10. The width W is 80 >> code, and a long-word holds N = 80 / W segments. Narrow data uses bits W-1..0 of its bus.
- R2: The k-th accepted write of a group (counting from 0) lands at bits k*W of the long-word. Bits of `wr_data` above W are ignored. A cycle with `wr_en` low adds nothing.
- R3: `lw_out_valid` rises in the cycle after the N-th write of a group is accepted, and carries the packed word on `lw_out_data`.
- R4: While `lw_out_valid` is high and `lw_out_ready` is low, the output word holds. `wr_ready` goes low only when the output is occupied, not being taken, and the next write would complete a long-word.
- R5: With low-first order (order input 0 at reset), segment i of a long-word appears as the i-th read word. With high-first order (input 1), the segment at bit position (N-1-i)*W appears i-th. Bits of `rd_data` above W read as zero.
- R6: A narrow read word is consumed when `rd_en` and `rd_valid` are both high. Otherwise `rd_valid` and `rd_data` hold.
- R7: `lw_in_ready` is high only when no long-word is held, or when the last segment of the held word is being consumed in that cycle.
- R8: Size codes and order are sampled while `rst_n` is low. Changes to those pins after reset have no effect until the next reset.
- R9: Straight after reset, `lw_out_valid` and `rd_valid` are 0 and `wr_ready` and `lw_in_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Master reset, active low, synchronous; samples configuration |
| cfg_wr_size | input | 2 | Write-side size code |
| cfg_rd_size | input | 2 | Read-side size code |
| cfg_rd_msb_first | input | 1 | Read order: 1 high segment first, 0 low segment first |
| wr_en | input | 1 | Narrow write enable |
| wr_data | input | 80 | Narrow write data on the low W bits |
| wr_ready | output | 1 | Write side can accept a narrow word |
| lw_out_valid | output | 1 | Packed long-word available |
| lw_out_data | output | 80 | Packed long-word |
| lw_out_ready | input | 1 | Store takes the packed long-word |
| lw_in_valid | input | 1 | Store offers a long-word |
| lw_in_data | input | 80 | Offered long-word |
| lw_in_ready | output | 1 | Read side requests a long-word |
| rd_en | input | 1 | Narrow read enable |
| rd_data | output | 80 | Narrow read data on the low W bits, zero above |
| rd_valid | output | 1 | A narrow read word is present |

## Verification
The bench runs every write width against every read width in both orders. It compares packed and unpacked words against values computed from the segment arithmetic. The write data carries non-zero bits above the width, which catches a packer that does not mask its input. Reads stall every few cycles, which catches an unpacker that advances or loses a segment while `rd_en` is low. The other cases are these. Back-pressure with a nearly full group catches a packer that overwrites a waiting long-word. A ready that rises before the last segment would show up as a skipped word. Size and order pins flipped after reset would show up as a wrong count of writes per word or as reversed segments.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int SIZE_LEVELS = 4;
    localparam int SEGS_MAX    = 1 << (SIZE_LEVELS - 1);
    localparam int CNT_W       = $clog2(SEGS_MAX);

    typedef enum logic [1:0] {
        SZ_FULL   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_QUART  = 2'b10,
        SZ_EIGHTH = 2'b11
    } bus_size_e;

    typedef struct packed {
        bus_size_e wr_size;
        bus_size_e rd_size;
        logic      msb_first;
    } bm_cfg_t;

    function automatic logic [CNT_W-1:0] last_seg(input bus_size_e sz);
        return CNT_W'((32'd1 << sz) - 32'd1);
    endfunction
endpackage

// File: rtl/bm_cfg.sv
module bm_cfg
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bm_cfg_t cfg_pins,
    output bm_cfg_t cfg
);
    bm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) cfg_d = cfg_pins;
    end

    always_ff @(posedge clk) cfg_q <= cfg_d;

    assign cfg = cfg_q;

    // R8: configuration frozen once reset has been released
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));
endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
#(
    parameter int LONG_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_size_e         size,
    input  logic              wr_en,
    input  logic [LONG_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              lw_valid,
    output logic [LONG_W-1:0] lw_data,
    input  logic              lw_ready
);
    typedef struct packed {
        logic [LONG_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [LONG_W-1:0] out;
    } pk_state_t;

    pk_state_t s_d, s_q;
    logic [LONG_W-1:0] ins [SIZE_LEVELS];
    logic [CNT_W-1:0]  last_idx;
    logic [1:0]        sz;

    assign sz       = size;
    assign last_idx = last_seg(size);

    for (genvar g = 0; g < SIZE_LEVELS; g++) begin : g_ins
        localparam int SW = LONG_W >> g;
        logic [LONG_W-1:0] msk;
        assign msk = LONG_W'({SW{1'b1}});
        always_comb ins[g] = (s_q.acc & ~(msk << (s_q.cnt * SW)))
                           | ((wr_data & msk) << (s_q.cnt * SW));
    end

    always_comb begin
        s_d      = s_q;
        wr_ready = !s_q.valid || lw_ready || (s_q.cnt != last_idx);
        if (s_q.valid && lw_ready) s_d.valid = 1'b0;
        if (wr_en && wr_ready) begin
            if (s_q.cnt == last_idx) begin
                s_d.out   = ins[sz];
                s_d.valid = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.acc = ins[sz];
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lw_valid = s_q.valid;
    assign lw_data  = s_q.out;

    // R4: an untaken long-word holds its value
    assert_lw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lw_valid && !lw_ready |=> lw_valid && $stable(lw_data));
    // R4: writes stall only while a full output waits
    assert_wr_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> lw_valid && !lw_ready);
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_pkg::*;
#(
    parameter int LONG_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_size_e         size,
    input  logic              msb_first,
    input  logic              lw_valid,
    input  logic [LONG_W-1:0] lw_data,
    output logic              lw_ready,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [LONG_W-1:0] rd_data
);
    typedef struct packed {
        logic [LONG_W-1:0] word;
        logic [CNT_W-1:0]  seg;
        logic              full;
    } up_state_t;

    up_state_t s_d, s_q;
    logic [LONG_W-1:0] cand [SIZE_LEVELS];
    logic [CNT_W-1:0]  last_idx, pos;
    logic [1:0]        sz;
    logic              consume, at_last;

    assign sz       = size;
    assign last_idx = last_seg(size);
    assign pos      = msb_first ? (last_idx - s_q.seg) : s_q.seg;

    for (genvar g = 0; g < SIZE_LEVELS; g++) begin : g_ext
        localparam int SW = LONG_W >> g;
        logic [LONG_W-1:0] msk;
        assign msk = LONG_W'({SW{1'b1}});
        always_comb cand[g] = (s_q.word >> (pos * SW)) & msk;
    end

    assign consume = rd_en && s_q.full;
    assign at_last = (s_q.seg == last_idx);

    always_comb begin
        s_d      = s_q;
        lw_ready = !s_q.full || (consume && at_last);
        if (consume) begin
            if (at_last) begin
                s_d.full = 1'b0;
                s_d.seg  = '0;
            end else begin
                s_d.seg = s_q.seg + 1'b1;
            end
        end
        if (lw_valid && lw_ready) begin
            s_d.word = lw_data;
            s_d.full = 1'b1;
            s_d.seg  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.full;
    assign rd_data  = s_q.full ? cand[sz] : '0;

    // R6: a word not consumed stays on the bus
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_en |=> rd_valid && $stable(rd_data));
    // R7: an accepted long-word makes data readable next cycle
    assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lw_valid && lw_ready |=> rd_valid);
    // R7: no request while segments of the held word remain
    assert_no_early_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_en |-> !lw_ready);
    // R5: nothing above the selected width
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> (LONG_W >> sz)) == '0);
endmodule

// File: rtl/bm_port_adapter.sv
module bm_port_adapter
    import bm_pkg::*;
#(
    parameter int LONG_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_wr_size,
    input  logic [1:0]        cfg_rd_size,
    input  logic              cfg_rd_msb_first,
    input  logic              wr_en,
    input  logic [LONG_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              lw_out_valid,
    output logic [LONG_W-1:0] lw_out_data,
    input  logic              lw_out_ready,
    input  logic              lw_in_valid,
    input  logic [LONG_W-1:0] lw_in_data,
    output logic              lw_in_ready,
    input  logic              rd_en,
    output logic [LONG_W-1:0] rd_data,
    output logic              rd_valid
);
    bm_cfg_t pins, cfg;

    assign pins.wr_size   = bus_size_e'(cfg_wr_size);
    assign pins.rd_size   = bus_size_e'(cfg_rd_size);
    assign pins.msb_first = cfg_rd_msb_first;

    bm_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_pins (pins),
        .cfg      (cfg)
    );

    bm_pack #(.LONG_W(LONG_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .size     (cfg.wr_size),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .lw_valid (lw_out_valid),
        .lw_data  (lw_out_data),
        .lw_ready (lw_out_ready)
    );

    bm_unpack #(.LONG_W(LONG_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .size      (cfg.rd_size),
        .msb_first (cfg.msb_first),
        .lw_valid  (lw_in_valid),
        .lw_data   (lw_in_data),
        .lw_ready  (lw_in_ready),
        .rd_en     (rd_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/test_bm_port_adapter.sv
`timescale 1ns/1ps
module test_bm_port_adapter;
    localparam int LW = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_wr_size = 2'b00, cfg_rd_size = 2'b00;
    logic cfg_rd_msb_first = 1'b0;
    logic wr_en = 1'b0;
    logic [LW-1:0] wr_data = '0;
    logic wr_ready, lw_out_valid, lw_in_ready, rd_valid;
    logic [LW-1:0] lw_out_data, rd_data;
    logic lw_out_ready = 1'b1;
    logic lw_in_valid = 1'b0;
    logic [LW-1:0] lw_in_data = '0;
    logic rd_en = 1'b0;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bm_port_adapter #(.LONG_W(LW)) i_bm_port_adapter (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_size(cfg_wr_size), .cfg_rd_size(cfg_rd_size),
        .cfg_rd_msb_first(cfg_rd_msb_first),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .lw_out_valid(lw_out_valid), .lw_out_data(lw_out_data),
        .lw_out_ready(lw_out_ready),
        .lw_in_valid(lw_in_valid), .lw_in_data(lw_in_data),
        .lw_in_ready(lw_in_ready),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] pat(input int k);
        return {16'hA5C3 ^ 16'(k), 32'h1234_5679 * 32'(k + 1),
                32'hDEAD_BEEF ^ 32'(k * 7919)};
    endfunction

    function automatic logic [LW-1:0] msk(input int w);
        return (w >= LW) ? '1 : ((LW'(1) << w) - LW'(1));
    endfunction

    function automatic logic [LW-1:0] packed_word(input int sz, input int j);
        int w = LW >> sz;
        int n = 1 << sz;
        logic [LW-1:0] r = '0;
        for (int i = 0; i < n; i++) r |= (pat(j * n + i) & msk(w)) << (i * w);
        return r;
    endfunction

    function automatic logic [LW-1:0] seg_of(input logic [LW-1:0] wd, input int sz,
                                             input bit msb, input int i);
        int w = LW >> sz;
        int n = 1 << sz;
        int p = msb ? (n - 1 - i) : i;
        return (wd >> (p * w)) & msk(w);
    endfunction

    task automatic do_reset(input int wsz, input int rsz, input bit msb);
        @(posedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b0; lw_in_valid = 1'b0; rd_en = 1'b0;
        lw_out_ready = 1'b1;
        cfg_wr_size = 2'(wsz); cfg_rd_size = 2'(rsz); cfg_rd_msb_first = msb;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // writes 2N narrow words with idle gaps; expects words of size wsz
    task automatic write_sweep(input int wsz);
        int n = 1 << wsz;
        for (int k = 0; k < 2 * n; k++) begin
            wr_en = 1'b1; wr_data = pat(k);
            @(posedge clk); #1;
            wr_en = 1'b0;
            chk(lw_out_valid == ((k % n) == n - 1), "R3 valid", LW'(lw_out_valid),
                LW'((k % n) == n - 1));
            if (lw_out_valid)
                chk(lw_out_data == packed_word(wsz, k / n), "R2 packed data",
                    lw_out_data, packed_word(wsz, k / n));
            if (k % 3 == 1) begin
                @(posedge clk); #1;
                chk(!lw_out_valid, "R2 idle cycle adds nothing", LW'(lw_out_valid), '0);
            end
        end
    endtask

    // feeds 3 long-words, reads with stalls; expects size rsz / order msb
    task automatic read_sweep(input int rsz, input bit msb, input int seed);
        int n = 1 << rsz;
        int widx = 0, m = 0, cyc = 0;
        bit hs, cons;
        while (m < 3 * n && cyc < 400) begin
            rd_en = (cyc % 4) != 2;
            lw_in_valid = widx < 3;
            lw_in_data = pat(seed + widx);
            @(negedge clk);
            if (rd_valid) begin
                chk(rd_data == seg_of(pat(seed + m / n), rsz, msb, m % n), "R5 segment",
                    rd_data, seg_of(pat(seed + m / n), rsz, msb, m % n));
                if (!(rd_en && (m % n) == n - 1))
                    chk(!lw_in_ready, "R7 early request", LW'(lw_in_ready), '0);
            end
            hs = lw_in_valid && lw_in_ready;
            cons = rd_en && rd_valid;
            @(posedge clk); #1;
            if (hs) widx++;
            if (cons) m++;
            cyc++;
        end
        rd_en = 1'b0; lw_in_valid = 1'b0;
        chk(m == 3 * n, "R6 all segments consumed", LW'(m), LW'(3 * n));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(0, 0, 0);
        #1;
        chk(!lw_out_valid && !rd_valid, "R9 valids low", LW'({lw_out_valid, rd_valid}), '0);
        chk(wr_ready && lw_in_ready, "R9 readies high", LW'({wr_ready, lw_in_ready}), LW'(3));

        // R1 R2 R3 R5: every width pair, both orders
        for (int ws = 0; ws < 4; ws++)
            for (int rs = 0; rs < 4; rs++)
                for (int b = 0; b < 2; b++) begin
                    do_reset(ws, rs, b[0]);
                    write_sweep(ws);
                    read_sweep(rs, b[0], 100 * (ws * 8 + rs * 2 + b));
                end

        // R4: back-pressure with 10-bit writes
        do_reset(3, 0, 0);
        lw_out_ready = 1'b0;
        for (int k = 0; k < 15; k++) begin
            wr_en = 1'b1; wr_data = pat(k);
            @(posedge clk); #1;
            wr_en = 1'b0;
            if (k >= 7 && k < 14)
                chk(wr_ready, "R4 ready while group incomplete", LW'(wr_ready), LW'(1));
        end
        chk(!wr_ready, "R4 stall before completing write", LW'(wr_ready), '0);
        wr_en = 1'b1; wr_data = pat(15);
        repeat (2) begin
            @(posedge clk); #1;
            chk(lw_out_valid && lw_out_data == packed_word(3, 0), "R4 held word",
                lw_out_data, packed_word(3, 0));
        end
        lw_out_ready = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk(lw_out_valid && lw_out_data == packed_word(3, 1), "R4 next word after release",
            lw_out_data, packed_word(3, 1));

        // R8: pins changed after reset are ignored
        do_reset(3, 2, 1);
        cfg_wr_size = 2'b00; cfg_rd_size = 2'b00; cfg_rd_msb_first = 1'b0;
        write_sweep(3);
        read_sweep(2, 1'b1, 7000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule